// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models the target side of a two-wire serial EEPROM inside a digital chip. It holds a byte array of 512 or 256 entries, chosen by parameter. A fast system clock oversamples the SCL and SDA lines through a glitch filter. Start and stop conditions are recognised from the filtered levels. SDA is driven only as an active-low enable, and the pad itself lies outside this block.

A host selects the block with a select byte. That byte carries a fixed code, the levels of three strap inputs and a read/write flag. The host then writes an address byte and up to a page of data, or reads bytes one after another from an address it set with a repeated start.

Written bytes collect in a page buffer and do not touch the array at once. The array is updated at the end of a fixed-length internal write period that begins at the stop condition. During that period the block does not answer its select byte, so a host can poll it to learn when the write is done. A write-protect input, sampled at the stop, cancels the pending write.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and no write period is running.
- R2: Select byte fields: bits [7:4] = 1010, bit 3 compared with `strap_i[2]`, bit 2 with `strap_i[1]`, bit 1 with `strap_i[0]`, bit 0 = 1 for read and 0 for write. On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R3: With MEM_DEPTH = 512, select bit 1 is array address bit 8 and `strap_i[0]` is not compared. With 256, all three strap bits are compared.
- R4: A write is made of a write select, an address byte and data bytes, each acknowledged. The array changes only at the end of the write period that follows the stop.
- R5: Data byte n of a write lands at in-page slot (address[2:0] + n) mod 8 of the addressed 8-byte page. It never crosses into another page, and a later byte overwrites an earlier one in the same slot.
- R6: A stop that follows at least one data byte starts a write period of exactly WRITE_CYCLES clock cycles. During that period any select byte is not acknowledged.
- R7: If `wp_i` is high at the stop, the buffered bytes are discarded, the array keeps its contents and no write period starts.
- R8: In a read, each byte that the host acknowledges advances the address by one, wrapping from the top of the array to 0.
- R9: An address byte, then a repeated start, then a read select returns the byte at that address.
- R10: A pulse shorter than FILT_LEN clock cycles on SCL or SDA has no effect on the transfer.
- R11: `sda_oe` changes only while the filtered SCL is low, so a data bit stays steady through the whole SCL high phase.
- R12: When the host does not acknowledge a read byte, the block releases SDA and waits for the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND with the block's own drive) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| strap_i | input | 3 | Select address straps |
| wp_i | input | 1 | Write protect, sampled at the stop condition |

## Verification
An acknowledge or a read data bit appears about FILT_LEN + 3 cycles after the raw SCL falling edge: two synchroniser stages, the filter count, the edge detector and the output register. The bench holds each SCL half period at 40 cycles and reads SDA 10 and 30 cycles into the high phase, so every sample falls well after the output has settled and before it may change again. An array update is due WRITE_CYCLES cycles after the filtered stop. The bench polls right after the stop to see the not-acknowledge, and it waits WRITE_CYCLES plus a margin before it reads back. The expected read bytes come from a model of the page-wrap and address-wrap rules, queued by the driver and compared as each received byte arrives.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_DEVSEL,
      S_ACK_DEV,
      S_ADDR,
      S_ACK_ADDR,
      S_WDATA,
      S_ACK_WDATA,
      S_RDATA,
      S_RACK
   } eep_state_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_glitch_filter.sv
module eep_glitch_filter #(
   parameter int FILT_LEN = 16,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int CW = $clog2(FILT_LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

   logic [1:0]    sync;
   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync <= {2{IDLE_VAL}};
         run  <= '0;
         q    <= IDLE_VAL;
      end else begin
         sync <= {sync[0], d};
         if (sync[1] == q) begin
            run <= '0;
         end else if (run == LAST) begin
            q   <= sync[1];
            run <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
   end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int DEPTH      = 512,
   parameter int PAGE_BYTES = 8
) (
   input  logic                           clk,
   input  logic                           we,
   input  logic [$clog2(DEPTH)-$clog2(PAGE_BYTES)-1:0] page,
   input  logic [PAGE_BYTES-1:0][7:0]     wdata,
   input  logic [PAGE_BYTES-1:0]          wmask,
   input  logic [$clog2(DEPTH)-1:0]       raddr,
   output logic [7:0]                     rdata
);
   localparam int SW = $clog2(PAGE_BYTES);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wmask[i]) mem[{page, SW'(i)}] <= wdata[i];
         end
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/eep_wcycle_timer.sv
module eep_wcycle_timer #(
   parameter int CYCLES = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else if (cnt == LAST) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = busy && (cnt == LAST);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
   parameter int MEM_DEPTH    = 512,
   parameter int PAGE_BYTES   = 8,
   parameter int WRITE_CYCLES = 2500000,
   parameter int FILT_LEN     = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);
   import eep_pkg::*;

   localparam int AW = $clog2(MEM_DEPTH);
   localparam int SW = $clog2(PAGE_BYTES);
   localparam int PW = AW - SW;
   // In the wide build, select bit 1 carries address bit 8 instead of a strap
   localparam logic [2:0] STRAP_MASK = (AW > 8) ? 3'b110 : 3'b111;

   if (MEM_DEPTH != 256 && MEM_DEPTH != 512) begin : g_bad_depth
      $error("MEM_DEPTH must be 256 or 512");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (WRITE_CYCLES < 2) begin : g_bad_wc
      $error("WRITE_CYCLES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("FILT_LEN must be at least 2");
   end

   // ---------------- bus sampling ----------------
   logic [1:0] raw_lines, filt_lines;
   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_filt
      eep_glitch_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_filt (
         .clk(clk), .rst_n(rst_n), .d(raw_lines[g]), .q(filt_lines[g])
      );
   end

   logic scl_f, sda_f, scl_d, sda_d;
   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   assign scl_rise  =  scl_f & ~scl_d;
   assign scl_fall  = ~scl_f &  scl_d;
   assign start_det =  scl_f &  scl_d &  sda_d & ~sda_f;
   assign stop_det  =  scl_f &  scl_d & ~sda_d &  sda_f;

   // ---------------- protocol state ----------------
   eep_state_e                    state;
   logic [3:0]                    bitcnt;
   logic [7:0]                    sr, tx, rdata;
   logic                          rw, ack_drv, mack;
   logic [AW-1:0]                 addr, addr_sel, addr_ld;
   logic [PW-1:0]                 page;
   logic [SW-1:0]                 slot;
   logic [PAGE_BYTES-1:0][7:0]    pbuf;
   logic [PAGE_BYTES-1:0]         pvalid;
   logic                          busy, commit, wstart, sel_ok;

   if (AW > 8) begin : g_wide
      assign addr_sel = {sr[1], addr[7:0]};
      assign addr_ld  = {addr[AW-1:8], sr};
   end else begin : g_narrow
      assign addr_sel = addr;
      assign addr_ld  = sr;
   end

   assign sel_ok = (sr[7:4] == DEV_CODE) &&
                   (((sr[3:1] ^ strap_i) & STRAP_MASK) == 3'b000) && !busy;
   assign wstart = stop_det && (|pvalid) && !wp_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         bitcnt  <= '0;
         sr      <= '0;
         tx      <= 8'hFF;
         rw      <= 1'b0;
         ack_drv <= 1'b0;
         mack    <= 1'b0;
         addr    <= '0;
         page    <= '0;
         slot    <= '0;
         pbuf    <= '0;
         pvalid  <= '0;
      end else begin
         if (commit) pvalid <= '0;
         if (start_det) begin
            state   <= S_DEVSEL;
            bitcnt  <= '0;
            ack_drv <= 1'b0;
            if (!busy) pvalid <= '0;
         end else if (stop_det) begin
            state   <= S_IDLE;
            ack_drv <= 1'b0;
            if (wp_i) pvalid <= '0;
         end else if (scl_rise) begin
            case (state)
               S_DEVSEL, S_ADDR, S_WDATA: begin
                  sr     <= {sr[6:0], sda_f};
                  bitcnt <= bitcnt + 4'd1;
               end
               S_RDATA: bitcnt <= bitcnt + 4'd1;
               S_RACK:  mack   <= ~sda_f;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               S_DEVSEL: if (bitcnt == 4'd8) begin
                  if (sel_ok) begin
                     ack_drv <= 1'b1;
                     rw      <= sr[0];
                     addr    <= addr_sel;
                     state   <= S_ACK_DEV;
                  end else begin
                     state <= S_IDLE;
                  end
               end
               S_ADDR: if (bitcnt == 4'd8) begin
                  addr    <= addr_ld;
                  page    <= addr_ld[AW-1:SW];
                  slot    <= addr_ld[SW-1:0];
                  ack_drv <= 1'b1;
                  state   <= S_ACK_ADDR;
               end
               S_WDATA: if (bitcnt == 4'd8) begin
                  pbuf[slot]   <= sr;
                  pvalid[slot] <= 1'b1;
                  slot         <= slot + 1'b1;
                  ack_drv      <= 1'b1;
                  state        <= S_ACK_WDATA;
               end
               S_ACK_DEV: begin
                  ack_drv <= 1'b0;
                  bitcnt  <= '0;
                  if (rw) begin
                     state <= S_RDATA;
                     tx    <= rdata;
                  end else begin
                     state <= S_ADDR;
                  end
               end
               S_ACK_ADDR, S_ACK_WDATA: begin
                  ack_drv <= 1'b0;
                  bitcnt  <= '0;
                  state   <= S_WDATA;
               end
               S_RDATA: if (bitcnt == 4'd8) begin
                  state <= S_RACK;
                  addr  <= addr + 1'b1;
               end else begin
                  tx <= {tx[6:0], 1'b1};
               end
               S_RACK: if (mack) begin
                  state  <= S_RDATA;
                  tx     <= rdata;
                  bitcnt <= '0;
               end else begin
                  state <= S_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = ack_drv | ((state == S_RDATA) & ~tx[7]);

   // ---------------- storage and write period ----------------
   eep_array #(.DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_array (
      .clk(clk), .we(commit), .page(page), .wdata(pbuf), .wmask(pvalid),
      .raddr(addr), .rdata(rdata)
   );

   eep_wcycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(wstart), .busy(busy), .done(commit)
   );
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
   parameter int WRITE_CYCLES = 2500000
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_f,
   input logic                  scl_fall,
   input logic                  sda_oe,
   input logic                  busy,
   input logic                  stop_det,
   input logic                  wp_i,
   input eep_pkg::eep_state_e   state,
   input logic [3:0]            bitcnt
);
   import eep_pkg::*;

   logic [31:0] blen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    blen <= '0;
      else if (busy) blen <= blen + 32'd1;
      else           blen <= '0;
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (blen == 32'(WRITE_CYCLES))); // R6

   AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && scl_fall && state == S_DEVSEL && bitcnt == 4'd8) |=> !sda_oe); // R6

   AST_WRITE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det)); // R4

   AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp_i)); // R7

   AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f); // R11
endmodule

bind i2c_eeprom_target eep_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_checker (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_fall(scl_fall),
   .sda_oe(sda_oe), .busy(busy), .stop_det(stop_det), .wp_i(wp_i),
   .state(state), .bitcnt(bitcnt)
);

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
   localparam int WC = 2000;
   localparam int Q  = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_h = 1'b1;
   logic       wp = 1'b0;
   logic [2:0] strap = 3'b101;
   logic       sda_oe;
   logic       sda_line;

   int nchecks = 0;
   int nerrors = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_h & ~sda_oe;

   i2c_eeprom_target #(.WRITE_CYCLES(WC)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
   );

   logic [7:0] model [512];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] obs_byte;
   logic       obs_pulse = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      nchecks++;
      if (!ok) begin
         nerrors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push_exp(input string tag, input logic [7:0] v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   // monitor: pops an expected byte for each byte the design returns
   initial begin
      forever begin
         @(posedge obs_pulse);
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard unexpected byte", obs_byte, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(obs_byte == e, t, obs_byte, e);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b, input bit glitch);
      sda_h = b;
      idle(Q / 2);
      if (glitch) begin
         scl = 1'b1; idle(4); scl = 1'b0; idle(Q / 2 - 4);
      end else begin
         idle(Q / 2);
      end
      scl = 1'b1;
      idle(Q);
      if (glitch && b) begin
         sda_h = 1'b0; idle(4); sda_h = 1'b1;
      end
      idle(Q);
      scl = 1'b0;
      idle(Q);
   endtask

   task automatic bit_in(output logic b, output bit steady);
      logic a, c;
      sda_h = 1'b1;
      idle(Q);
      scl = 1'b1;
      idle(Q / 2);
      a = sda_line;
      idle(Q);
      c = sda_line;
      idle(Q / 2);
      scl = 1'b0;
      idle(Q);
      b = a;
      steady = (a == c);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; idle(Q);
      scl = 1'b1;   idle(Q);
      sda_h = 1'b0; idle(Q);
      scl = 1'b0;   idle(Q);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; idle(Q);
      scl = 1'b1;   idle(Q);
      sda_h = 1'b1; idle(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
      logic b;
      bit s;
      for (int i = 7; i >= 0; i--) bit_out(v[i], glitch);
      bit_in(b, s);
      acked = (b == 1'b0);
   endtask

   task automatic recv_byte(input bit host_ack, input string tag);
      logic [7:0] v;
      bit st, all_st;
      all_st = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bit_in(v[i], st);
         all_st &= st;
      end
      check(all_st, "R11 read bit steady while SCL high", all_st, 1);
      obs_byte = v;
      obs_pulse = 1'b1;
      idle(1);
      obs_pulse = 1'b0;
      bit_out(host_ack ? 1'b0 : 1'b1, 1'b0);
      if (tag.len() == 0) ;
   endtask

   task automatic set_addr(input logic [8:0] a);
      bit ack;
      bus_start();
      send_byte({4'b1010, 2'b10, a[8], 1'b0}, 1'b0, ack);
      check(ack, "R9 write select before read", ack, 1);
      send_byte(a[7:0], 1'b0, ack);
      check(ack, "R9 address byte acked", ack, 1);
      bus_start();
      send_byte({4'b1010, 2'b10, a[8], 1'b1}, 1'b0, ack);
      check(ack, "R9 read select after repeated start", ack, 1);
   endtask

   task automatic run_tests();
      bit ack;
      logic [2:0] s;

      idle(10);
      rst_n = 1'b1;
      idle(5);
      check(sda_oe == 1'b0, "R1 reset SDA released", sda_oe, 0);

      // R2: strap mismatch on select bit 3
      bus_start();
      send_byte(8'b1010_0000, 1'b0, ack);
      check(!ack, "R2 mismatched select not acked", ack, 0);
      bus_stop();

      // R4/R5: ten bytes from in-page slot 6 wrap inside page 0
      bus_start();
      send_byte(8'b1010_1000, 1'b0, ack);
      check(ack, "R2 R3 select acked, strap bit 0 ignored", ack, 1);
      send_byte(8'h06, 1'b0, ack);
      check(ack, "R4 address acked", ack, 1);
      for (int k = 0; k < 10; k++) begin
         send_byte(8'hA0 + 8'(k), 1'b0, ack);
         check(ack, "R4 data byte acked", ack, 1);
         s = 3'(6 + k);
         model[{6'd0, s}] = 8'hA0 + 8'(k);
      end
      bus_stop();

      // R6: poll during the write period
      bus_start();
      send_byte(8'b1010_1000, 1'b0, ack);
      check(!ack, "R6 select ignored while busy", ack, 0);
      bus_stop();
      idle(WC + 100);

      // R6/R9/R5/R8: random read of the whole page
      set_addr(9'h000);
      for (int k = 0; k < 8; k++) begin
         push_exp("R5 R8 page wrap readback", model[k]);
         recv_byte(k != 7, "");
      end
      check(sda_oe == 1'b0, "R12 SDA released after host NACK", sda_oe, 0);
      bus_stop();
      check(sda_oe == 1'b0, "R12 idle after stop", sda_oe, 0);

      // R3/R8: top address, read wraps to 0
      bus_start();
      send_byte(8'b1010_1010, 1'b0, ack);
      check(ack, "R3 select with address bit 8 acked", ack, 1);
      send_byte(8'hFF, 1'b0, ack);
      send_byte(8'h5A, 1'b0, ack);
      check(ack, "R4 data byte acked", ack, 1);
      bus_stop();
      model[9'h1FF] = 8'h5A;
      idle(WC + 100);
      set_addr(9'h1FF);
      push_exp("R3 byte at top address", model[9'h1FF]);
      recv_byte(1'b1, "");
      push_exp("R8 wrap to address 0", model[0]);
      recv_byte(1'b1, "");
      push_exp("R8 increment after wrap", model[1]);
      recv_byte(1'b0, "");
      bus_stop();

      // R7: write protect at stop
      wp = 1'b1;
      bus_start();
      send_byte(8'b1010_1000, 1'b0, ack);
      send_byte(8'h03, 1'b0, ack);
      send_byte(8'hEE, 1'b0, ack);
      bus_stop();
      idle(10);
      wp = 1'b0;
      set_addr(9'h003);
      push_exp("R7 protected byte unchanged", model[3]);
      recv_byte(1'b0, "");
      bus_stop();

      // R10: glitches on both lines during a write
      bus_start();
      send_byte(8'b1010_1000, 1'b1, ack);
      check(ack, "R10 glitched select acked", ack, 1);
      send_byte(8'h10, 1'b1, ack);
      check(ack, "R10 glitched address acked", ack, 1);
      send_byte(8'h33, 1'b1, ack);
      check(ack, "R10 glitched data acked", ack, 1);
      bus_stop();
      model[9'h010] = 8'h33;
      idle(WC + 100);
      set_addr(9'h010);
      push_exp("R10 glitched write readback", model[9'h010]);
      recv_byte(1'b0, "");
      bus_stop();

      idle(20);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
   endtask

   initial begin
      run_tests();
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
   end
endmodule